// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an EDO DRAM array alive. After reset it waits out the start-up pause, which is 200 µs at the default parameters. It then runs eight back-to-back refresh cycles and raises `init_done`. Host accesses are refused until `init_done` is high.

After initialization an interval timer fires once per refresh slot. The slot is 15.6 µs when `mode_8k` is low (4096 refreshes per 64 ms) and 7.8 µs when it is high (8192 per 64 ms), both at a 100 MHz clock. Each firing adds one to a pending count. When the array is not being used by the access sequencer (`bus_busy` low), the block takes the RAS, CAS and W strobes, marks this with `pins_own`, and drains every pending refresh back to back. Each refresh is a CAS-before-RAS cycle: the DRAM's internal row counter selects the row, so address and data pins are don't-care and the data bus is never driven.

While `bus_busy` is high, missed slots accumulate up to a limit of eight. A slot that arrives when the count is already full sets a sticky error flag.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are 1, and `pins_own`, `init_done`, `ovf_err` and `host_accept` are 0.
- R2: No RAS falling edge occurs during the first INIT_WAIT cycles after reset is released.
- R3: After the pause, exactly INIT_CYC (8) refresh cycles run back to back and then `init_done` rises. While `init_done` is 0, `host_accept` is 0. Once `init_done` is 1 and `pins_own` is 0, `host_accept` follows `host_req` one cycle later.
- R4: In every refresh cycle `cas_n` falls exactly CSR_CYC (2) cycles before `ras_n` falls, and rises exactly CHR_CYC (2) cycles after `ras_n` falls.
- R5: `ras_n` stays low for exactly RAS_CYC (7) cycles. Between two consecutive refresh cycles, `ras_n` stays high for at least RP_CYC+CSR_CYC (6) cycles.
- R6: `we_n` is 1 whenever `pins_own` is 1. When `pins_own` is 0, `ras_n` and `cas_n` rest at 1.
- R7: With `mode_8k`=0, RAS falling edges in steady state are IVL_4K cycles apart. With `mode_8k`=1 they are IVL_8K cycles apart.
- R8: While `bus_busy` is 1 and the block is idle, no refresh cycle starts. Each slot that fires during that time runs as a refresh once `bus_busy` drops, with falling edges 13 cycles apart. No other refresh cycle runs.
- R9: The pending count saturates at MAX_PEND (8). A slot that arrives at a full count sets `ovf_err`, and `ovf_err` stays 1 until reset. Such a slot adds no refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| mode_8k | input | 1 | 0: 4096 refreshes per 64 ms, 1: 8192 per 64 ms |
| bus_busy | input | 1 | Access sequencer is using the array |
| host_req | input | 1 | Host asks to start an access |
| host_accept | output | 1 | Host access allowed (registered) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| pins_own | output | 1 | Block drives the strobes; otherwise it releases them |
| init_done | output | 1 | Power-up sequence finished |
| ovf_err | output | 1 | Sticky pending-count overflow |

## Verification
Refresh timing is exercised under four bus patterns:
- the idle start-up burst, which confirms that the pause and the initial burst are counted exactly;
- free-running slots in each density mode, which separates the two interval lengths;
- a short busy window, which shows deferred slots drained back to back and distinguishes queuing from dropping;
- a long busy window, which crosses the count limit and separates saturation from wrap-around.

Every cycle in all four patterns is measured for strobe ordering, RAS width and precharge spacing.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CSET, PH_RLOW, PH_PRE} phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/drs_timer.sv
// Start-up pause counter and refresh slot timer.
module drs_timer #(
  parameter int INIT_WAIT = 20000,
  parameter int IVL_4K    = 1560,
  parameter int IVL_8K    = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_8k,
  input  logic run,
  output logic pause_done,
  output logic tick
);
  localparam int PW = $clog2(INIT_WAIT + 1);
  localparam int IW = $clog2(drs_pkg::max2(IVL_4K, IVL_8K) + 1);

  logic [PW-1:0] pcnt;
  logic          waiting;
  logic [IW-1:0] icnt;
  logic [IW-1:0] lim_m1;

  assign lim_m1 = mode_8k ? IW'(IVL_8K - 1) : IW'(IVL_4K - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt       <= '0;
      waiting    <= 1'b1;
      pause_done <= 1'b0;
    end else begin
      pause_done <= 1'b0;
      if (waiting) begin
        if (pcnt == PW'(INIT_WAIT - 1)) begin
          waiting    <= 1'b0;
          pause_done <= 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

  // >= keeps the period bounded when the mode switches to the shorter slot
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      icnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (icnt >= lim_m1) begin
        icnt <= '0;
        tick <= 1'b1;
      end else begin
        icnt <= icnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/drs_pend.sv
// Saturating count of refreshes still owed, with sticky overflow.
module drs_pend #(
  parameter int MAX_PEND = 8,
  parameter int INIT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_init,
  input  logic tick,
  input  logic done_one,
  output logic pend_nz,
  output logic ovf_err
);
  localparam int CW = $clog2(drs_pkg::max2(MAX_PEND, INIT_CYC) + 1);

  logic [CW-1:0] count;

  assign pend_nz = (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      ovf_err <= 1'b0;
    end else if (load_init) begin
      count <= CW'(INIT_CYC);
    end else begin
      case ({tick, done_one})
        2'b10: begin
          if (count >= CW'(MAX_PEND)) ovf_err <= 1'b1;
          else                        count   <= count + 1'b1;
        end
        2'b01: begin
          if (count != '0) count <= count - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/drs_seq.sv
// CAS-before-RAS cycle generator; holds the strobes until the count drains.
module drs_seq
  import drs_pkg::*;
#(
  parameter int CSR_CYC = 2,
  parameter int CHR_CYC = 2,
  parameter int RAS_CYC = 7,
  parameter int RP_CYC  = 4   // at least 2: the count must settle before the end check
) (
  input  logic clk,
  input  logic rst,
  input  logic pend_nz,
  input  logic bus_busy,
  input  logic force_go,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic own,
  output logic done_one
);
  localparam int CNT_W = $clog2(max2(max2(CSR_CYC, RAS_CYC), RP_CYC) + 1);

  phase_e           ph;
  logic [CNT_W-1:0] ctr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      ctr      <= '0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      own      <= 1'b0;
      done_one <= 1'b0;
    end else begin
      done_one <= 1'b0;
      we_n     <= 1'b1;
      unique case (ph)
        PH_IDLE: begin
          if (pend_nz && (!bus_busy || force_go)) begin
            ph    <= PH_CSET;
            ctr   <= '0;
            own   <= 1'b1;
            cas_n <= 1'b0;
          end
        end
        PH_CSET: begin
          if (ctr == CNT_W'(CSR_CYC - 1)) begin
            ph    <= PH_RLOW;
            ctr   <= '0;
            ras_n <= 1'b0;
          end else begin
            ctr <= ctr + 1'b1;
          end
        end
        PH_RLOW: begin
          if (ctr == CNT_W'(CHR_CYC - 1)) cas_n <= 1'b1;
          if (ctr == CNT_W'(RAS_CYC - 1)) begin
            ph       <= PH_PRE;
            ctr      <= '0;
            ras_n    <= 1'b1;
            cas_n    <= 1'b1;
            done_one <= 1'b1;
          end else begin
            ctr <= ctr + 1'b1;
          end
        end
        PH_PRE: begin
          if (ctr == CNT_W'(RP_CYC - 1)) begin
            ctr <= '0;
            if (pend_nz) begin
              ph    <= PH_CSET;
              cas_n <= 1'b0;
            end else begin
              ph  <= PH_IDLE;
              own <= 1'b0;
            end
          end else begin
            ctr <= ctr + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INIT_WAIT = 20000,
  parameter int IVL_4K    = 1560,
  parameter int IVL_8K    = 780,
  parameter int INIT_CYC  = 8,
  parameter int MAX_PEND  = 8,
  parameter int CSR_CYC   = 2,
  parameter int CHR_CYC   = 2,
  parameter int RAS_CYC   = 7,
  parameter int RP_CYC    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_8k,
  input  logic bus_busy,
  input  logic host_req,
  output logic host_accept,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic pins_own,
  output logic init_done,
  output logic ovf_err
);
  logic pause_done, tick, pend_nz, done_one, init_loaded;

  drs_timer #(.INIT_WAIT(INIT_WAIT), .IVL_4K(IVL_4K), .IVL_8K(IVL_8K)) u_timer (
    .clk(clk), .rst(rst), .mode_8k(mode_8k), .run(init_done),
    .pause_done(pause_done), .tick(tick)
  );

  drs_pend #(.MAX_PEND(MAX_PEND), .INIT_CYC(INIT_CYC)) u_pend (
    .clk(clk), .rst(rst), .load_init(pause_done), .tick(tick),
    .done_one(done_one), .pend_nz(pend_nz), .ovf_err(ovf_err)
  );

  drs_seq #(.CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_seq (
    .clk(clk), .rst(rst), .pend_nz(pend_nz), .bus_busy(bus_busy),
    .force_go(init_loaded && !init_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .own(pins_own), .done_one(done_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_loaded <= 1'b0;
      init_done   <= 1'b0;
      host_accept <= 1'b0;
    end else begin
      if (pause_done) init_loaded <= 1'b1;
      if (init_loaded && !pend_nz && !pins_own) init_done <= 1'b1;
      host_accept <= host_req && init_done && !pins_own;
    end
  end
endmodule

// File: rtl/drs_chk.sv
module drs_chk #(
  parameter int RAS_CYC = 7
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic pins_own,
  input logic init_done,
  input logic ovf_err,
  input logic host_accept
);
  logic [7:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)         low_run <= '0;
    else if (!ras_n) low_run <= low_run + 1'b1;
    else             low_run <= '0;
  end

  // R4
  cas_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_run == 8'(RAS_CYC)));

  // R6
  we_high_chk: assert property (@(posedge clk) disable iff (rst)
    pins_own |-> we_n);

  // R6
  released_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pins_own |-> (ras_n && cas_n));

  // R3
  host_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !host_accept);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  // R9
  ovf_post_init_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !ovf_err);
endmodule

bind dram_refresh_sched drs_chk #(.RAS_CYC(RAS_CYC)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .pins_own(pins_own), .init_done(init_done), .ovf_err(ovf_err),
  .host_accept(host_accept)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int INIT_WAIT = 300;
  localparam int IVL_4K    = 200;
  localparam int IVL_8K    = 100;
  localparam int CSR_CYC   = 2;
  localparam int CHR_CYC   = 2;
  localparam int RAS_CYC   = 7;
  localparam int RP_CYC    = 4;
  localparam int B2B       = CSR_CYC + RAS_CYC + RP_CYC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_8k = 1'b0, bus_busy = 1'b0, host_req = 1'b0;
  logic host_accept, ras_n, cas_n, we_n, pins_own, init_done, ovf_err;

  always #5 clk = ~clk;

  dram_refresh_sched #(.INIT_WAIT(INIT_WAIT), .IVL_4K(IVL_4K), .IVL_8K(IVL_8K),
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u0 (
    .clk(clk), .rst(rst), .mode_8k(mode_8k), .bus_busy(bus_busy), .host_req(host_req),
    .host_accept(host_accept), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .pins_own(pins_own), .init_done(init_done), .ovf_err(ovf_err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {int lead; int low; int hold;} cyc_t;
  cyc_t expq[$];
  int   fall_times[$];
  int   fall_count = 0;

  // driver side of the scoreboard
  task automatic expect_cycles(input int n);
    for (int i = 0; i < n; i++) expq.push_back('{CSR_CYC, RAS_CYC, CHR_CYC});
  endtask

  // monitor: measures every refresh cycle and pops its expected shape
  int  t = 0, cas_fall_t = 0, ras_fall_t = 0, ras_rise_t = 0, cur_lead = 0, cur_hold = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  always @(negedge clk) begin
    t++;
    if (!rst) begin
      if (prev_cas && !cas_n && ras_n) cas_fall_t = t;
      if (prev_ras && !ras_n) begin
        ras_fall_t = t;
        fall_count++;
        fall_times.push_back(t);
        cur_lead = t - cas_fall_t;
        if (ras_rise_t > 0) check(t - ras_rise_t >= RP_CYC + CSR_CYC, "R5 precharge", t - ras_rise_t, RP_CYC + CSR_CYC);
      end
      if (!prev_cas && cas_n && !ras_n) cur_hold = t - ras_fall_t;
      if (!prev_ras && ras_n) begin
        ras_rise_t = t;
        if (expq.size() == 0) begin
          check(1'b0, "R8 unexpected refresh", fall_count, 0);
        end else begin
          cyc_t e;
          e = expq.pop_front();
          check(cur_lead == e.lead, "R4 cas lead", cur_lead, e.lead);
          check(cur_hold == e.hold, "R4 cas hold", cur_hold, e.hold);
          check(t - ras_fall_t == e.low, "R5 ras width", t - ras_fall_t, e.low);
        end
      end
      if (pins_own && !we_n) check(1'b0, "R6 we high", 0, 1);
      if (!pins_own && !(ras_n && cas_n)) check(1'b0, "R6 released idle", 0, 1);
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_falls(input int target, input int lim, input string req);
    int k = 0;
    while (fall_count < target && k < lim) begin
      step(1);
      k++;
    end
    check(fall_count >= target, req, fall_count, target);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int b;
    step(5);
    // R1 reset state
    check(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    check(!pins_own && !init_done, "R1 own/init", {pins_own, init_done}, 0);
    check(!ovf_err && !host_accept, "R1 err/accept", {ovf_err, host_accept}, 0);
    rst = 1'b0;

    // R2 pause, R3 refusal during init
    host_req = 1'b1;
    step(250);
    check(fall_count == 0, "R2 no refresh in pause", fall_count, 0);
    check(host_accept == 1'b0, "R3 refused before init", host_accept, 0);

    // R3 eight-cycle burst
    expect_cycles(8);
    b = 0;
    while (!init_done && b < 600) begin step(1); b++; end
    check(init_done == 1'b1, "R3 init_done", init_done, 1);
    check(fall_count == 8, "R3 init cycles", fall_count, 8);
    check(expq.size() == 0, "R3 init drained", expq.size(), 0);
    check(fall_times[7] - fall_times[6] == B2B, "R5 back to back", fall_times[7] - fall_times[6], B2B);
    step(2);
    check(host_accept == 1'b1, "R3 accept after init", host_accept, 1);
    host_req = 1'b0;
    step(2);
    check(host_accept == 1'b0, "R3 accept follows req", host_accept, 0);

    // R7 4K slot spacing
    expect_cycles(3);
    wait_falls(11, 800, "R7 4K falls");
    check(fall_times[9] - fall_times[8] == IVL_4K, "R7 4K spacing", fall_times[9] - fall_times[8], IVL_4K);
    check(fall_times[10] - fall_times[9] == IVL_4K, "R7 4K spacing", fall_times[10] - fall_times[9], IVL_4K);

    // R7 8K slot spacing
    mode_8k = 1'b1;
    expect_cycles(3);
    wait_falls(14, 500, "R7 8K falls");
    check(fall_times[13] - fall_times[12] == IVL_8K, "R7 8K spacing", fall_times[13] - fall_times[12], IVL_8K);

    // R8 short busy window: four slots deferred
    bus_busy = 1'b1;
    step(420);
    check(fall_count == 14, "R8 held while busy", fall_count, 14);
    check(pins_own == 1'b0, "R8 released while busy", pins_own, 0);
    expect_cycles(5);
    bus_busy = 1'b0;
    wait_falls(19, 200, "R8 deferred falls");
    for (int i = 15; i <= 17; i++)
      check(fall_times[i] - fall_times[i-1] == B2B, "R8 burst spacing", fall_times[i] - fall_times[i-1], B2B);
    check(fall_times[18] - fall_times[17] > B2B, "R8 burst length", fall_times[18] - fall_times[17], B2B + 1);

    // R9 long busy window: nine slots, count saturates at eight
    bus_busy = 1'b1;
    step(820);
    check(ovf_err == 1'b0, "R9 no overflow at eight", ovf_err, 0);
    step(100);
    check(ovf_err == 1'b1, "R9 overflow set", ovf_err, 1);
    expect_cycles(9);
    bus_busy = 1'b0;
    wait_falls(28, 200, "R9 drain falls");
    check(fall_times[27] - fall_times[19] == 8 * B2B, "R9 drain back to back", fall_times[27] - fall_times[19], 8 * B2B);
    step(20);
    check(fall_count == 28, "R9 saturated count", fall_count, 28);
    check(expq.size() == 0, "R8 scoreboard empty", expq.size(), 0);
    check(ovf_err == 1'b1, "R9 overflow sticky", ovf_err, 1);
    finish_run();
  end
endmodule